// File: doc/BRIEF.md
# Password-Gated Command Access Controller

This block decides, for each monitor command offered to it, whether the command may run at once, must wait for a password, or is refused. The decision depends on a security level held in a stored mode byte, an eight-slot stored password, and whether the operator has already proved the password since the monitor was last entered. A separate input stream delivers typed password bytes and an end strobe. Every rejected attempt is counted in a 16-bit counter that stops at its maximum value.

The block keeps its settings in two register sets. Writes through the configuration port go to a staged copy. The live copy, which drives every decision, is loaded from the staged copy only when a monitor-entry pulse arrives. Writes are accepted only while the live level is open, or once the password has been given. Character parsing, persistent storage and the command interpreter are outside the block.

Top module: `cmd_access_gate`

## Requirements
- R1: The live mode byte selects the level. The value 0x01 selects command-protected, 0x5E selects fully protected, and any other value selects open. After reset both copies of the mode byte and all eight password slots are zero, so the level is open.
- R2: At the open level, a `cmd_valid` strobe of any class raises `grant` for exactly one cycle, in the cycle after the strobe, and `pw_req` stays low. Class codes on `cmd_class` are: 0 for continue without parameters, 1 for boot without parameters, and 2 or 3 for any other command.
- R3: At the command-protected level, classes 0 and 1 are granted at once. Classes 2 and 3 raise `pw_req` in the cycle after the strobe and produce no grant.
- R4: At the fully protected level, only class 0 is granted at once. Classes 1, 2 and 3 raise `pw_req`.
- R5: While `pw_req` is high, typed bytes fill the entry slots in order. Entry closes after a zero byte or after eight bytes, and later bytes are ignored. Untyped slots count as zero, and all eight slots are compared on `key_end`. On a match, `grant` pulses once, `pw_req` falls, and the block stays unlocked, granting every command at once until the next monitor-entry pulse.
- R6: A mismatch on `key_end` raises `deny` for one cycle, adds one to `fail_count`, keeps `pw_req` high so the operator can retry, and empties the entry.
- R7: `fail_count` saturates at 65535 and never wraps to 0.
- R8: `fail_count` is zero after reset and returns to zero only through `cnt_clear`. A successful password does not clear it.
- R9: Configuration writes land in the staged copy. Address 0 to 7 selects a password slot, address 8 selects the mode byte, and other addresses write nothing. The live copy changes only on `monitor_enter`, which also clears the unlocked state and drops any pending request.
- R10: A configuration write is ignored when the live level is protected and the block is not unlocked.
- R11: `key_end` and `key_valid` have no effect while no request is pending: no deny, and no change to the count.
- R12: `grant` and `deny` are never high together. When `cnt_clear` arrives in the same cycle as a failed attempt, the clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command offered this cycle |
| cmd_class | input | 2 | 0 continue, 1 boot (both without parameters), 2/3 other |
| key_valid | input | 1 | Typed password byte present |
| key_byte | input | 8 | Typed password byte |
| key_end | input | 1 | Password entry finished |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | 0-7 password slot, 8 mode byte |
| cfg_wdata | input | 8 | Configuration write data |
| monitor_enter | input | 1 | Monitor re-entry; loads the live copy |
| cnt_clear | input | 1 | Clears the failure counter |
| grant | output | 1 | One-cycle permission pulse |
| deny | output | 1 | One-cycle rejected-password pulse |
| pw_req | output | 1 | A command is waiting for the password |
| fail_count | output | 16 | Saturating count of rejected attempts |

## Verification
The level decision is driven from a table that pairs mode bytes with command classes. The mode bytes include the two protected codes and the neighbouring values 0x02, 0x5F and 0xFF, which tells an exact compare apart from a partial one. Each class is tried against each level, which separates the free list of the command-protected level from that of the fully protected level. Password entries include a short password ended by a zero byte with junk after it, a full eight-byte password with a ninth byte, and a seven-byte prefix that must fail. These separate zero-termination, the eight-slot limit and whole-width comparison. Directed sequences cover staged-versus-live writes, writes refused while locked, strobes with no pending request, clear-versus-increment in the same cycle, and running the counter past 65535.

// File: rtl/cag_pkg.sv
// Shared types and decode helpers for the command access controller.
// Assumes an 8-bit mode byte; the two protected codes are fixed.
package cag_pkg;
    localparam logic [7:0] MODE_CODE_CMD  = 8'h01;
    localparam logic [7:0] MODE_CODE_FULL = 8'h5E;

    typedef enum logic [1:0] {
        LVL_OPEN = 2'd0,
        LVL_CMD  = 2'd1,
        LVL_FULL = 2'd2
    } sec_level_t;

    typedef enum logic [1:0] {
        CC_CONT   = 2'd0,
        CC_BOOT   = 2'd1,
        CC_OTHER  = 2'd2,
        CC_OTHER2 = 2'd3
    } cmd_class_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } gate_state_t;

    // Map a raw mode byte onto a security level.
    function automatic sec_level_t decode_level(input logic [7:0] code);
        if (code == MODE_CODE_CMD)       return LVL_CMD;
        else if (code == MODE_CODE_FULL) return LVL_FULL;
        else                             return LVL_OPEN;
    endfunction

    // True when a command class needs no password at the given level.
    function automatic logic cmd_is_free(input sec_level_t lvl, input cmd_class_t cls);
        case (lvl)
            LVL_OPEN: return 1'b1;
            LVL_CMD:  return (cls == CC_CONT) || (cls == CC_BOOT);
            LVL_FULL: return (cls == CC_CONT);
            default:  return 1'b1;
        endcase
    endfunction
endpackage

// File: rtl/cag_secure_store.sv
// Staged and live copies of the mode byte and the password slots.
// Writes reach the staged copy only when wr_allow is high; the live
// copy is loaded from the staged copy on activate.
module cag_secure_store
    import cag_pkg::*;
#(
    parameter int SLOTS  = 8,
    parameter int BYTE_W = 8,
    localparam int ADDR_W = $clog2(SLOTS) + 1,
    localparam int PW_W   = SLOTS * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              wr_allow,
    input  logic              activate,
    output sec_level_t        act_level,
    output logic [PW_W-1:0]   act_pw
);
    logic [7:0]        stg_mode_q;
    logic [7:0]        act_mode_q;
    logic [PW_W-1:0]   stg_pw_q;
    logic [PW_W-1:0]   act_pw_q;

    // Staged mode byte: written at the address just past the slots.
    always_ff @(posedge clk) begin
        if (!rst_n)
            stg_mode_q <= '0;
        else if (wr_en && wr_allow && (wr_addr == ADDR_W'(SLOTS)))
            stg_mode_q <= wr_data[7:0];
    end

    // Staged password slots, one writer per slot.
    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n)
                stg_pw_q[s*BYTE_W +: BYTE_W] <= '0;
            else if (wr_en && wr_allow && (wr_addr == ADDR_W'(s)))
                stg_pw_q[s*BYTE_W +: BYTE_W] <= wr_data;
        end
    end

    // Live copy: loaded only when the monitor is entered.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_mode_q <= '0;
            act_pw_q   <= '0;
        end else if (activate) begin
            act_mode_q <= stg_mode_q;
            act_pw_q   <= stg_pw_q;
        end
    end

    assign act_level = decode_level(act_mode_q);
    assign act_pw    = act_pw_q;

    // R9: the live level moves only on an activate pulse.
    assert_live_level_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !activate |=> $stable(act_level));
    // R9: the live password moves only on an activate pulse.
    assert_live_pw_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !activate |=> $stable(act_pw));
endmodule

// File: rtl/cag_pw_entry.sv
// Collects typed password bytes into slots and compares them with the
// live password. Entry closes on a zero byte or when all slots are
// filled; flush empties the buffer. Untyped slots hold zero.
module cag_pw_entry #(
    parameter int SLOTS  = 8,
    parameter int BYTE_W = 8,
    localparam int IDX_W = $clog2(SLOTS + 1),
    localparam int PW_W  = SLOTS * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              key_valid,
    input  logic [BYTE_W-1:0] key_byte,
    input  logic [PW_W-1:0]   ref_pw,
    output logic              match
);
    logic [PW_W-1:0]  buf_q;
    logic [IDX_W-1:0] idx_q;
    logic             closed_q;
    logic             take;
    logic [SLOTS-1:0] slot_eq;

    assign take = key_valid && !flush && !closed_q && (idx_q < IDX_W'(SLOTS));

    // Position and closure tracking for the entry.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            idx_q    <= '0;
            closed_q <= 1'b0;
        end else if (take) begin
            idx_q <= idx_q + 1'b1;
            if (key_byte == '0)
                closed_q <= 1'b1;
        end
    end

    // Per-slot capture and compare.
    for (genvar s = 0; s < SLOTS; s++) begin : g_cmp
        always_ff @(posedge clk) begin
            if (!rst_n || flush)
                buf_q[s*BYTE_W +: BYTE_W] <= '0;
            else if (take && (idx_q == IDX_W'(s)))
                buf_q[s*BYTE_W +: BYTE_W] <= key_byte;
        end
        assign slot_eq[s] = (buf_q[s*BYTE_W +: BYTE_W] == ref_pw[s*BYTE_W +: BYTE_W]);
    end

    assign match = &slot_eq;

    // R5: the write position never runs past the last slot.
    always_comb begin
        if (rst_n)
            assert_idx_bound_R5: assert (idx_q <= IDX_W'(SLOTS));
    end
    // R5: nothing is captured once entry has closed.
    assert_closed_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (closed_q && !flush) |=> $stable(buf_q));
endmodule

// File: rtl/cag_fail_counter.sv
// Saturating counter of rejected password attempts. Only clr lowers it,
// and clr wins over a same-cycle increment.
module cag_fail_counter #(
    parameter int CNT_W = 16,
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}}
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             clr,
    output logic [CNT_W-1:0] count
);
    logic [CNT_W-1:0] cnt_q;

    // Count failures, holding at the top value.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            cnt_q <= '0;
        else if (inc && (cnt_q != CNT_MAX))
            cnt_q <= cnt_q + 1'b1;
    end

    assign count = cnt_q;

    // R7: a full counter stays full when more failures arrive.
    assert_no_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !clr && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX));
    // R8: without a clear the count never goes down.
    assert_monotonic_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (cnt_q >= $past(cnt_q)));
    // R12: a clear always leaves zero.
    assert_clear_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt_q == '0));
endmodule

// File: rtl/cmd_access_gate.sv
// Top of the command access controller. Decides grant or password
// request for each command, runs password attempts, tracks the unlocked
// state and counts failures. Assumes key_end arrives in a cycle of its
// own, after the last key_valid byte.
module cmd_access_gate
    import cag_pkg::*;
#(
    parameter int SLOTS  = 8,
    parameter int BYTE_W = 8,
    parameter int CNT_W  = 16,
    localparam int ADDR_W = $clog2(SLOTS) + 1,
    localparam int PW_W   = SLOTS * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_class,
    input  logic              key_valid,
    input  logic [BYTE_W-1:0] key_byte,
    input  logic              key_end,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [BYTE_W-1:0] cfg_wdata,
    input  logic              monitor_enter,
    input  logic              cnt_clear,
    output logic              grant,
    output logic              deny,
    output logic              pw_req,
    output logic [CNT_W-1:0]  fail_count
);
    gate_state_t     state_q;
    logic            unlocked_q;
    logic            grant_q;
    logic            deny_q;
    sec_level_t      level;
    logic [PW_W-1:0] live_pw;
    logic            pw_match;
    logic            attempt;
    logic            flush;
    logic            fail_inc;
    logic            cmd_free;

    cag_secure_store #(.SLOTS(SLOTS), .BYTE_W(BYTE_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cfg_we),
        .wr_addr   (cfg_addr),
        .wr_data   (cfg_wdata),
        .wr_allow  ((level == LVL_OPEN) || unlocked_q),
        .activate  (monitor_enter),
        .act_level (level),
        .act_pw    (live_pw)
    );

    cag_pw_entry #(.SLOTS(SLOTS), .BYTE_W(BYTE_W)) u_entry (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .key_valid (key_valid),
        .key_byte  (key_byte),
        .ref_pw    (live_pw),
        .match     (pw_match)
    );

    cag_fail_counter #(.CNT_W(CNT_W)) u_fails (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (fail_inc),
        .clr   (cnt_clear),
        .count (fail_count)
    );

    assign cmd_free = cmd_is_free(level, cmd_class_t'(cmd_class)) || unlocked_q;
    assign attempt  = (state_q == ST_WAIT) && key_end && !cmd_valid && !monitor_enter;
    assign flush    = (state_q != ST_WAIT) || cmd_valid || key_end || monitor_enter;
    assign fail_inc = attempt && !pw_match;

    // Request state, unlock flag and one-cycle result pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            unlocked_q <= 1'b0;
            grant_q    <= 1'b0;
            deny_q     <= 1'b0;
        end else begin
            grant_q <= 1'b0;
            deny_q  <= 1'b0;
            if (monitor_enter) begin
                state_q    <= ST_IDLE;
                unlocked_q <= 1'b0;
            end else if (cmd_valid) begin
                if (cmd_free) begin
                    grant_q <= 1'b1;
                    state_q <= ST_IDLE;
                end else begin
                    state_q <= ST_WAIT;
                end
            end else if (attempt) begin
                if (pw_match) begin
                    grant_q    <= 1'b1;
                    unlocked_q <= 1'b1;
                    state_q    <= ST_IDLE;
                end else begin
                    deny_q <= 1'b1;
                end
            end
        end
    end

    assign grant  = grant_q;
    assign deny   = deny_q;
    assign pw_req = (state_q == ST_WAIT);

    // R12: a grant and a deny never coincide.
    assert_grant_deny_excl_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(grant && deny));
    // R6: a deny leaves the request pending for a retry.
    assert_deny_keeps_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
        deny |-> pw_req);
    // R11: with no request pending, an end strobe never yields a deny.
    assert_idle_end_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!pw_req && key_end && !cmd_valid) |=> !deny);
    // R9: monitor entry drops any pending request.
    assert_enter_drops_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
        monitor_enter |=> (!pw_req && !grant));
endmodule

// File: tb/cmd_access_gate_bench.sv
module cmd_access_gate_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cmd_valid, key_valid, key_end, cfg_we, monitor_enter, cnt_clear;
    logic [1:0]  cmd_class;
    logic [7:0]  key_byte, cfg_wdata;
    logic [3:0]  cfg_addr;
    logic        grant, deny, pw_req;
    logic [15:0] fail_count;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    cmd_access_gate u_cmd_access_gate (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_class(cmd_class),
        .key_valid(key_valid), .key_byte(key_byte), .key_end(key_end),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .monitor_enter(monitor_enter), .cnt_clear(cnt_clear),
        .grant(grant), .deny(deny), .pw_req(pw_req), .fail_count(fail_count)
    );

    always #2 clk = ~clk;

    // Each entry: mode byte, command class, expected immediate grant.
    localparam logic [10:0] VEC [14] = '{
        {8'h00, 2'd0, 1'b1}, {8'h00, 2'd1, 1'b1}, {8'h00, 2'd2, 1'b1},
        {8'h01, 2'd0, 1'b1}, {8'h01, 2'd1, 1'b1}, {8'h01, 2'd2, 1'b0},
        {8'h01, 2'd3, 1'b0}, {8'h5E, 2'd0, 1'b1}, {8'h5E, 2'd1, 1'b0},
        {8'h5E, 2'd2, 1'b0}, {8'h5E, 2'd3, 1'b0}, {8'h02, 2'd2, 1'b1},
        {8'h5F, 2'd1, 1'b1}, {8'hFF, 2'd3, 1'b1}
    };

    task automatic tick();
        @(posedge clk);
        #1;
        cycles++;
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic idle_inputs();
        cmd_valid = 0; key_valid = 0; key_end = 0; cfg_we = 0;
        monitor_enter = 0; cnt_clear = 0; cmd_class = 0; key_byte = 0;
        cfg_addr = 0; cfg_wdata = 0;
    endtask

    task automatic do_reset();
        idle_inputs();
        rst_n = 0;
        tick(); tick();
        rst_n = 1;
    endtask

    task automatic cfg_write(input logic [3:0] a, input logic [7:0] d);
        cfg_we = 1; cfg_addr = a; cfg_wdata = d;
        tick();
        cfg_we = 0;
    endtask

    task automatic enter_mon();
        monitor_enter = 1;
        tick();
        monitor_enter = 0;
    endtask

    task automatic issue(input logic [1:0] c);
        cmd_valid = 1; cmd_class = c;
        tick();
        cmd_valid = 0;
    endtask

    task automatic type_byte(input logic [7:0] b);
        key_valid = 1; key_byte = b;
        tick();
        key_valid = 0;
    endtask

    task automatic end_entry();
        key_end = 1;
        tick();
        key_end = 0;
    endtask

    // Watchdog: an expired run counts as a failure and still reports.
    initial begin
        #700000;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        do_reset();
        // Reset state (R1, R8)
        chk("R8 reset count", fail_count, 0);
        chk("R1 reset pw_req", pw_req, 0);
        chk("R2 reset grant", grant, 0);
        chk("R6 reset deny", deny, 0);
        issue(2'd2);
        chk("R1 reset level open", grant, 1);

        // Level decision table (R1, R2, R3, R4)
        foreach (VEC[i]) begin
            do_reset();
            cfg_write(4'd8, VEC[i][10:3]);
            enter_mon();
            issue(VEC[i][2:1]);
            if (VEC[i][10:3] == 8'h01) begin
                chk("R1/R3 grant", grant, VEC[i][0]);
                chk("R3 pw_req", pw_req, !VEC[i][0]);
            end else if (VEC[i][10:3] == 8'h5E) begin
                chk("R1/R4 grant", grant, VEC[i][0]);
                chk("R4 pw_req", pw_req, !VEC[i][0]);
            end else begin
                chk("R1/R2 grant", grant, VEC[i][0]);
                chk("R2 pw_req", pw_req, 0);
            end
            tick();
            chk("R2 grant one cycle", grant, 0);
        end

        // Staged writes and deferred activation (R9)
        do_reset();
        cfg_write(4'd0, "a");
        cfg_write(4'd1, "b");
        cfg_write(4'd8, 8'h01);
        issue(2'd2);
        chk("R9 staged not live", grant, 1);
        enter_mon();
        issue(2'd2);
        chk("R9 live after enter", pw_req, 1);
        chk("R3 no grant", grant, 0);

        // Wrong password (R6)
        type_byte("a"); type_byte("x");
        end_entry();
        chk("R6 deny", deny, 1);
        chk("R6 count", fail_count, 1);
        chk("R6 still pending", pw_req, 1);
        tick();
        chk("R6 deny one cycle", deny, 0);

        // Zero-terminated correct password with trailing junk (R5, R8)
        type_byte("a"); type_byte("b"); type_byte(8'h00); type_byte("z");
        end_entry();
        chk("R5 match grant", grant, 1);
        chk("R5 req drops", pw_req, 0);
        chk("R8 success keeps count", fail_count, 1);
        issue(2'd3);
        chk("R5 unlocked grants", grant, 1);

        // Re-entry relocks (R9)
        enter_mon();
        issue(2'd2);
        chk("R9 relocked", pw_req, 1);
        issue(2'd0);
        chk("R3 free cmd while pending", grant, 1);
        chk("R3 pending replaced", pw_req, 0);

        // Strobes without a pending request (R11)
        type_byte("q");
        end_entry();
        chk("R11 no deny", deny, 0);
        chk("R11 count held", fail_count, 1);

        // Locked writes ignored (R10)
        cfg_write(4'd8, 8'h00);
        cfg_write(4'd0, "z");
        enter_mon();
        issue(2'd2);
        chk("R10 mode write ignored", pw_req, 1);
        type_byte("a"); type_byte("b");
        end_entry();
        chk("R10 pw write ignored", grant, 1);

        // Full-width password while unlocked (R5)
        for (int s = 0; s < 8; s++) cfg_write(4'(s), 8'h61 + 8'(s));
        cfg_write(4'd8, 8'h5E);
        enter_mon();
        issue(2'd1);
        chk("R4 boot needs pw", pw_req, 1);
        for (int s = 0; s < 7; s++) type_byte(8'h61 + 8'(s));
        end_entry();
        chk("R5 seven-byte prefix fails", deny, 1);
        for (int s = 0; s < 9; s++) type_byte(8'h61 + 8'(s));
        end_entry();
        chk("R5 ninth byte ignored", grant, 1);
        chk("R6 count after prefix", fail_count, 2);

        // Clear beats a same-cycle failure (R12)
        enter_mon();
        issue(2'd2);
        key_end = 1; cnt_clear = 1;
        tick();
        key_end = 0; cnt_clear = 0;
        chk("R12 clear wins", fail_count, 0);
        chk("R12 deny seen", deny, 1);
        chk("R12 exclusive", grant, 0);

        // Saturation (R7)
        key_end = 1;
        for (int n = 0; n < 65535; n++) tick();
        chk("R7 reaches max", fail_count, 65535);
        tick();
        key_end = 0;
        chk("R7 no wrap", fail_count, 65535);
        chk("R7 deny at max", deny, 1);
        cnt_clear = 1;
        tick();
        cnt_clear = 0;
        chk("R8 clear input", fail_count, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule